// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address for a single word, halfword or byte load or store, together with the value a base register would be updated to. It takes the 32-bit instruction word, the values of the base register and the index register, the current carry flag and the result of the condition check. From these it selects an offset and adds it to the base or subtracts it from the base. The offset is either a 12-bit immediate or the index register passed through a shift unit. It then decides whether the address used for the access is the base before or after that arithmetic, and whether the updated base is to be written back.

The computation is registered once, so every request accepted on `in_valid` produces its result one clock later with `out_valid`. The updated base value is always presented on `wb_val`, and `wb_en` tells the register file whether to take it. Memory access, lane steering and the register file itself belong to neighbouring blocks.

Top module: `lsag_top`

## Requirements
- R1: Instruction bit 23 set adds the offset to the base value; bit 23 clear subtracts the offset from the base value.
- R2: With instruction bit 25 clear, the offset is the zero-extended field in instruction bits [11:0].
- R3: With bit 25 set and bits [11:4] all zero, the offset is the index register value unchanged.
- R4: With bit 25 set, bits [6:5] = 0 select a left shift of the index register by the amount in bits [11:7].
- R5: Bits [6:5] = 1 select a logical right shift by the amount; an amount of zero gives an offset of 0.
- R6: Bits [6:5] = 2 select an arithmetic right shift by the amount; an amount of zero gives all ones when index bit 31 is set and all zeros otherwise.
- R7: Bits [6:5] = 3 select a right rotation by the amount; an amount of zero gives {carry_in, index[31:1]}.
- R8: With bit 24 set (pre-indexed), `mem_addr` equals the base combined with the offset, and `wb_val` carries the same value.
- R9: With bit 24 clear (post-indexed), `mem_addr` equals the unmodified base value while `wb_val` is the base combined with the offset.
- R10: `wb_en` is 1 only for an accepted request whose condition passed and that is post-indexed or has bit 21 set.
- R11: Address arithmetic wraps modulo 2^32 in both directions.
- R12: Results appear one clock after `in_valid`, flagged by `out_valid`; reset clears `out_valid` and `wb_en`, and a cycle without `in_valid` yields `out_valid` = 0 and `wb_en` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| instr | input | 32 | Load/store instruction word |
| rn_val | input | 32 | Base register value |
| rm_val | input | 32 | Index register value |
| carry_in | input | 1 | Current carry flag, used by rotate-with-extend |
| cond_pass | input | 1 | Condition check of the instruction passed |
| out_valid | output | 1 | Result valid, one clock after the request |
| mem_addr | output | 32 | Address for the memory access |
| wb_en | output | 1 | Base register update requested |
| wb_val | output | 32 | New base register value |

## Verification
Post-indexing sends the untouched base to `mem_addr` and, in the same cycle, sends the modified base to `wb_val`. The write-back decision is taken in that cycle too. The bench provokes this with post-indexed requests whose condition passes and with requests whose condition fails. It judges that the access address stays at the old base in both cases, that the updated value is still formed, and that only `wb_en` follows the condition. Pre-indexed requests with and without bit 21 show that `mem_addr` and `wb_val` agree while `wb_en` changes alone.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
   typedef enum logic [1:0] {
      IDX_LSL = 2'd0,
      IDX_LSR = 2'd1,
      IDX_ASR = 2'd2,
      IDX_ROR = 2'd3
   } idx_shift_e;

   localparam int unsigned BIT_IMMSEL = 25;
   localparam int unsigned BIT_PRE    = 24;
   localparam int unsigned BIT_UP     = 23;
   localparam int unsigned BIT_WBACK  = 21;
   localparam int unsigned IMM_W      = 12;
   localparam int unsigned AMT_LSB    = 7;
   localparam int unsigned AMT_W      = 5;
   localparam int unsigned TYPE_LSB   = 5;
endpackage

// File: rtl/lsag_index_shift.sv
module lsag_index_shift
   import lsag_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] idx_in,
   input  idx_shift_e        kind,
   input  logic [AMT_W-1:0]  amount,
   input  logic              carry_in,
   output logic [DATA_W-1:0] idx_out
);
   localparam int unsigned MSB = DATA_W - 1;

   logic              amt_zero;
   logic [DATA_W-1:0] lsl_v, lsr_v, asr_v, ror_v;
   logic [2*DATA_W-1:0] dbl;

   assign amt_zero = (amount == '0);
   assign dbl      = {idx_in, idx_in} >> amount;

   always_comb begin
      lsl_v = idx_in << amount;
      lsr_v = amt_zero ? '0 : (idx_in >> amount);
      asr_v = amt_zero ? {DATA_W{idx_in[MSB]}}
                       : DATA_W'($signed(idx_in) >>> amount);
      ror_v = amt_zero ? {carry_in, idx_in[MSB:1]} : dbl[DATA_W-1:0];
      unique case (kind)
         IDX_LSL: idx_out = lsl_v;
         IDX_LSR: idx_out = lsr_v;
         IDX_ASR: idx_out = asr_v;
         IDX_ROR: idx_out = ror_v;
         default: idx_out = lsl_v;
      endcase
   end
endmodule

// File: rtl/lsag_addsub.sv
module lsag_addsub #(
   parameter int unsigned DATA_W       = 32,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic [DATA_W-1:0] base,
   input  logic [DATA_W-1:0] offset,
   input  logic              up,
   output logic [DATA_W-1:0] result
);
   generate
      if (SHARED_ADDER) begin : g_shared
         logic [DATA_W-1:0] opnd;
         logic [DATA_W-1:0] cin;
         assign opnd   = offset ^ {DATA_W{~up}};
         assign cin    = {{(DATA_W-1){1'b0}}, ~up};
         assign result = base + opnd + cin;
      end else begin : g_split
         logic [DATA_W-1:0] sum_v, dif_v;
         assign sum_v  = base + offset;
         assign dif_v  = base - offset;
         assign result = up ? sum_v : dif_v;
      end
   endgenerate
endmodule

// File: rtl/lsag_top.sv
module lsag_top
   import lsag_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned INSTR_W      = 32,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [INSTR_W-1:0] instr,
   input  logic [DATA_W-1:0] rn_val,
   input  logic [DATA_W-1:0] rm_val,
   input  logic              carry_in,
   input  logic              cond_pass,
   output logic              out_valid,
   output logic [DATA_W-1:0] mem_addr,
   output logic              wb_en,
   output logic [DATA_W-1:0] wb_val
);
   localparam int unsigned PAD_W = DATA_W - IMM_W;

   generate
      if (INSTR_W != 32) begin : g_bad_instr
         $error("lsag_top: INSTR_W must be 32");
      end
      if (DATA_W < 32 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
         $error("lsag_top: DATA_W must be a power of two of at least 32");
      end
   endgenerate

   logic              use_index, pre_idx, up_dir, wback;
   idx_shift_e        kind;
   logic [AMT_W-1:0]  amount;
   logic [DATA_W-1:0] imm_ext, idx_val, offset, new_base, addr_nx;
   logic              wb_nx;

   assign use_index = instr[BIT_IMMSEL];
   assign pre_idx   = instr[BIT_PRE];
   assign up_dir    = instr[BIT_UP];
   assign wback     = instr[BIT_WBACK];
   assign kind      = idx_shift_e'(instr[TYPE_LSB +: 2]);
   assign amount    = instr[AMT_LSB +: AMT_W];
   assign imm_ext   = {{PAD_W{1'b0}}, instr[IMM_W-1:0]};

   lsag_index_shift #(.DATA_W(DATA_W)) u_shift (
      .idx_in   (rm_val),
      .kind     (kind),
      .amount   (amount),
      .carry_in (carry_in),
      .idx_out  (idx_val)
   );

   assign offset = use_index ? idx_val : imm_ext;

   lsag_addsub #(.DATA_W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) u_add (
      .base   (rn_val),
      .offset (offset),
      .up     (up_dir),
      .result (new_base)
   );

   assign addr_nx = pre_idx ? new_base : rn_val;
   assign wb_nx   = in_valid & cond_pass & (~pre_idx | wback);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         wb_en     <= 1'b0;
         mem_addr  <= '0;
         wb_val    <= '0;
      end else begin
         out_valid <= in_valid;
         wb_en     <= wb_nx;
         if (in_valid) begin
            mem_addr <= addr_nx;
            wb_val   <= new_base;
         end
      end
   end
endmodule

// File: rtl/lsag_chk.sv
module lsag_chk #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned INSTR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [INSTR_W-1:0] instr,
   input logic [DATA_W-1:0] rn_val,
   input logic              cond_pass,
   input logic              out_valid,
   input logic [DATA_W-1:0] mem_addr,
   input logic              wb_en,
   input logic [DATA_W-1:0] wb_val
);
   // R12
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !wb_en));
   // R10
   cond_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !cond_pass) |=> !wb_en);
   // R10
   pre_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[24] && !instr[21]) |=> !wb_en);
   // R9
   post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !instr[24]) |=> (mem_addr == $past(rn_val)));
   // R8
   pre_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[24]) |=> (mem_addr == wb_val));
   // R2
   imm_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !instr[25] && instr[23]) |=>
         (wb_val == $past(rn_val) + {{(DATA_W-12){1'b0}}, $past(instr[11:0])}));
endmodule

bind lsag_top lsag_chk #(.DATA_W(DATA_W), .INSTR_W(INSTR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .instr     (instr),
   .rn_val    (rn_val),
   .cond_pass (cond_pass),
   .out_valid (out_valid),
   .mem_addr  (mem_addr),
   .wb_en     (wb_en),
   .wb_val    (wb_val)
);

// File: tb/lsag_top_tb.sv
module lsag_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] rn_val = '0;
   logic [31:0] rm_val = '0;
   logic        carry_in = 1'b0;
   logic        cond_pass = 1'b0;
   logic        out_valid;
   logic [31:0] mem_addr;
   logic        wb_en;
   logic [31:0] wb_val;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   lsag_top u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .rn_val(rn_val), .rm_val(rm_val), .carry_in(carry_in),
      .cond_pass(cond_pass), .out_valid(out_valid), .mem_addr(mem_addr),
      .wb_en(wb_en), .wb_val(wb_val)
   );

   function automatic logic [31:0] enc_imm(bit p, bit u, bit w, logic [11:0] imm);
      return {4'hE, 3'b010, p, u, 1'b0, w, 1'b1, 4'h1, 4'h2, imm};
   endfunction

   function automatic logic [31:0] enc_idx(bit p, bit u, bit w, logic [1:0] kind,
                                           logic [4:0] amt);
      return {4'hE, 3'b011, p, u, 1'b0, w, 1'b1, 4'h1, 4'h2, amt, kind, 1'b0, 4'h3};
   endfunction

   task automatic check32(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic issue(logic [31:0] ins, logic [31:0] rn, logic [31:0] rm,
                        bit c, bit cp);
      @(negedge clk);
      instr = ins; rn_val = rn; rm_val = rm; carry_in = c; cond_pass = cp;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic expect_res(string req, logic [31:0] a, bit we, logic [31:0] wv);
      check32(req, "out_valid", {31'b0, out_valid}, 32'd1);
      check32(req, "mem_addr", mem_addr, a);
      check32(req, "wb_en", {31'b0, wb_en}, {31'b0, we});
      check32(req, "wb_val", wv === 'x ? wb_val : wb_val, wv);
   endtask

   task automatic t_reset();
      check32("R12", "reset out_valid", {31'b0, out_valid}, 32'd0);
      check32("R12", "reset wb_en", {31'b0, wb_en}, 32'd0);
   endtask

   task automatic t_imm();
      // R1 R2 R8: pre-indexed add, no write-back
      issue(enc_imm(1, 1, 0, 12'h123), 32'h0000_1000, 32'h0, 0, 1);
      expect_res("R2", 32'h0000_1123, 0, 32'h0000_1123);
      // R1 R10: pre-indexed subtract with write-back
      issue(enc_imm(1, 0, 1, 12'h010), 32'h0000_1000, 32'h0, 0, 1);
      expect_res("R1", 32'h0000_0FF0, 1, 32'h0000_0FF0);
      // R11: wrap below zero
      issue(enc_imm(1, 0, 0, 12'h001), 32'h0, 32'h0, 0, 1);
      expect_res("R11", 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF);
   endtask

   task automatic t_post();
      // R9 R10: post-indexed, condition passes
      issue(enc_imm(0, 1, 0, 12'h008), 32'h0000_2000, 32'h0, 0, 1);
      expect_res("R9", 32'h0000_2000, 1, 32'h0000_2008);
      // R10: post-indexed, condition fails in the same cycle
      issue(enc_imm(0, 1, 0, 12'h008), 32'h0000_2000, 32'h0, 0, 0);
      expect_res("R10", 32'h0000_2000, 0, 32'h0000_2008);
   endtask

   task automatic t_index();
      // R3 plain register offset, subtracted
      issue(enc_idx(1, 0, 0, 2'd0, 5'd0), 32'h100, 32'h30, 0, 1);
      expect_res("R3", 32'h0000_00D0, 0, 32'h0000_00D0);
      // R4 left shift by 2
      issue(enc_idx(1, 1, 0, 2'd0, 5'd2), 32'h100, 32'h4, 0, 1);
      expect_res("R4", 32'h0000_0110, 0, 32'h0000_0110);
      // R5 logical right, amount zero gives 0
      issue(enc_idx(1, 1, 0, 2'd1, 5'd0), 32'h100, 32'hFFFF, 0, 1);
      expect_res("R5", 32'h0000_0100, 0, 32'h0000_0100);
      // R5 logical right by 4
      issue(enc_idx(1, 1, 0, 2'd1, 5'd4), 32'h100, 32'hF0, 0, 1);
      expect_res("R5", 32'h0000_010F, 0, 32'h0000_010F);
      // R6 arithmetic, amount zero negative -> all ones; R11 wrap upward
      issue(enc_idx(1, 1, 0, 2'd2, 5'd0), 32'h5, 32'h8000_0000, 0, 1);
      expect_res("R6", 32'h0000_0004, 0, 32'h0000_0004);
      // R6 arithmetic, amount zero positive -> zero
      issue(enc_idx(1, 1, 0, 2'd2, 5'd0), 32'h5, 32'h7FFF_FFFF, 0, 1);
      expect_res("R6", 32'h0000_0005, 0, 32'h0000_0005);
      // R6 arithmetic right by 4
      issue(enc_idx(1, 1, 0, 2'd2, 5'd4), 32'h0, 32'h8000_0000, 0, 1);
      expect_res("R6", 32'hF800_0000, 0, 32'hF800_0000);
      // R7 rotate-with-extend
      issue(enc_idx(1, 1, 0, 2'd3, 5'd0), 32'h0, 32'h3, 1, 1);
      expect_res("R7", 32'h8000_0001, 0, 32'h8000_0001);
      // R7 rotate by 8, post-indexed with write-back
      issue(enc_idx(0, 1, 0, 2'd3, 5'd8), 32'h10, 32'h1234_5678, 0, 1);
      expect_res("R7", 32'h0000_0010, 1, 32'h7812_3466);
   endtask

   task automatic t_idle();
      // R12: a cycle without a request clears out_valid and wb_en
      issue(enc_imm(0, 1, 1, 12'h004), 32'h40, 32'h0, 0, 1);
      @(negedge clk);
      check32("R12", "idle out_valid", {31'b0, out_valid}, 32'd0);
      check32("R12", "idle wb_en", {31'b0, wb_en}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_imm();
      t_post();
      t_index();
      t_idle();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule